// File: doc/BRIEF.md
# Operand Barrel Shifter with Carry

This block forms the second operand of a 32-bit ALU. It also forms the carry that a logical operation writes back to the flags. It is purely combinational. A source selector chooses how the operand is made:

- A register value shifted by a 5-bit amount taken from the instruction.
- A register value shifted by an 8-bit amount taken from a second register.
- An 8-bit constant rotated right by twice a 4-bit field.

A 2-bit code picks the shift type. The current carry flag is an input. Every case that does not move any bits passes it straight through.

Several amount values are special. In the instruction-amount form, a zero amount means a full-width shift for the right shifts and a one-bit rotate through carry for the rotate. Register amounts beyond the word width saturate. The logical shifts give zero and a zero carry, and the arithmetic right shift gives the sign. Register reads and the ALU sit outside the block. Widths are parameters, checked for consistency when the design is elaborated.

Top module: `opnd_shifter`

## Requirements
- R1: The shift type code is 0 logical left, 1 logical right, 2 arithmetic right and 3 rotate right. For amounts 1 to 31 the result is the shifted value, and the carry is the last bit shifted out: bit 32-n for a left shift, bit n-1 for the right shifts and rotate.
- R2: Source code 0 (instruction amount) with amount 0 and logical right gives result 0 and carry = bit 31. With arithmetic right it gives every bit equal to bit 31, and carry = bit 31.
- R3: Source code 0 with amount 0 and rotate right gives a one-bit rotate through carry. The result is {carry_in, value[31:1]} and the carry is value[0].
- R4: Source code 0 with amount 0 and logical left leaves the value unchanged, and the carry equals carry_in.
- R5: Source code 1 (register amount) uses an 8-bit amount. An amount of 0 leaves the value unchanged and the carry equal to carry_in, for every shift type.
- R6: Source code 1 with a logical shift by exactly 32 gives result 0. The carry is bit 0 for a left shift and bit 31 for a right shift. Any amount of 33 or more gives result 0 and carry 0.
- R7: Source code 1 with arithmetic right by 32 or more gives every bit equal to bit 31, and carry = bit 31.
- R8: Source code 1 with rotate right and a nonzero amount rotates by the amount modulo 32. When the low 5 bits are zero the value is unchanged and the carry is bit 31.
- R9: Source code 2 (rotated constant) zero-extends the 8-bit constant and rotates it right by twice the 4-bit field. The carry is bit 31 of the result when the field is nonzero, and carry_in when it is zero.
- R10: Source code 3 passes the register value unchanged with carry = carry_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_sel | input | 2 | Operand source: 0 instruction amount, 1 register amount, 2 rotated constant, 3 raw register |
| shift_kind | input | 2 | Shift type code (ignored for source 2 and 3) |
| base_val | input | 32 | Register value to be shifted |
| amt_byte | input | 8 | Shift amount read from a register (source 1) |
| imm_amt | input | 5 | Shift amount from the instruction (source 0) |
| imm_byte | input | 8 | Constant for source 2 |
| imm_rot | input | 4 | Rotate field for source 2, rotation is twice its value |
| c_in | input | 1 | Current carry flag |
| opnd_out | output | 32 | Shifted operand |
| c_out | output | 1 | Shifter carry-out |

## Verification
The immediate assertions in the top module treat all inputs as settled, two-state values. They guard the saturating and pass-through corners: a zero register amount, logical overflow, arithmetic saturation, the rotate through carry, the zero rotate field and the raw source. The bench changes inputs only on the falling clock edge and samples two time units later, so every check sees a settled combinational result. Directed amounts of 0, 1, 31, 32, 33, 64 and 255 cover each special corner. A pseudo-random sweep covers the sources 0 to 2 with every code inside its defined range.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
   typedef enum logic [1:0] {
      SK_LSL = 2'd0,
      SK_LSR = 2'd1,
      SK_ASR = 2'd2,
      SK_ROR = 2'd3
   } shift_kind_e;

   typedef enum logic [1:0] {
      OS_IMM_AMT = 2'd0,
      OS_REG_AMT = 2'd1,
      OS_ROT_IMM = 2'd2,
      OS_RAW     = 2'd3
   } opnd_src_e;
endpackage

// File: rtl/opsh_plan.sv
// Turns the selected operand form into one canonical request:
// value, shift type, saturated amount, rotate-through-carry, or hold.
module opsh_plan
   import opsh_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_AMT_W = 5,
   parameter int REG_AMT_W = 8,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   parameter int AMT_W     = 6
) (
   input  opnd_src_e             src,
   input  shift_kind_e           kind,
   input  logic [DATA_W-1:0]     reg_val,
   input  logic [REG_AMT_W-1:0]  amt_byte,
   input  logic [IMM_AMT_W-1:0]  imm_amt,
   input  logic [IMM_W-1:0]      imm_val,
   input  logic [ROT_W-1:0]      imm_rot,
   output logic [DATA_W-1:0]     data,
   output shift_kind_e           eff_kind,
   output logic [AMT_W-1:0]      eff_amt,
   output logic                  rrx,
   output logic                  hold
);
   localparam int LOG_W = $clog2(DATA_W);
   localparam logic [AMT_W-1:0]     AMT_FULL = AMT_W'(DATA_W);
   localparam logic [AMT_W-1:0]     AMT_OVER = AMT_W'(DATA_W + 1);
   localparam logic [REG_AMT_W-1:0] REG_FULL = REG_AMT_W'(DATA_W);

   always_comb begin
      data     = reg_val;
      eff_kind = kind;
      eff_amt  = '0;
      rrx      = 1'b0;
      hold     = 1'b0;
      unique case (src)
         OS_IMM_AMT: begin
            if (imm_amt == '0) begin
               case (kind)
                  SK_LSL:         hold    = 1'b1;
                  SK_LSR, SK_ASR: eff_amt = AMT_FULL;
                  default:        rrx     = 1'b1;
               endcase
            end else begin
               eff_amt = AMT_W'(imm_amt);
            end
         end
         OS_REG_AMT: begin
            if (amt_byte == '0) begin
               hold = 1'b1;
            end else begin
               case (kind)
                  SK_LSL, SK_LSR:
                     eff_amt = (amt_byte > REG_FULL) ? AMT_OVER : AMT_W'(amt_byte);
                  SK_ASR:
                     eff_amt = (amt_byte >= REG_FULL) ? AMT_FULL : AMT_W'(amt_byte);
                  default:
                     eff_amt = (amt_byte[LOG_W-1:0] == '0) ? AMT_FULL
                                                           : AMT_W'(amt_byte[LOG_W-1:0]);
               endcase
            end
         end
         OS_ROT_IMM: begin
            data     = DATA_W'(imm_val);
            eff_kind = SK_ROR;
            if (imm_rot == '0) hold = 1'b1;
            else               eff_amt = AMT_W'({imm_rot, 1'b0});
         end
         default: hold = 1'b1;
      endcase
   end

   always_comb begin
      AST_AMT_SATURATED: assert (eff_amt <= AMT_OVER)
         else $error("amount beyond saturation");   // R6
      AST_ONE_SPECIAL: assert (!(rrx && hold))
         else $error("rotate-through-carry and hold together");   // R3
   end
endmodule

// File: rtl/opsh_rotator.sv
// Logarithmic right rotator, one stage per amount bit.
module opsh_rotator #(
   parameter int DATA_W = 32,
   parameter int LOG_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic [LOG_W-1:0]  rot,
   output logic [DATA_W-1:0] dout
);
   logic [DATA_W-1:0] stg [0:LOG_W];

   assign stg[0] = din;

   for (genvar k = 0; k < LOG_W; k++) begin : g_stage
      localparam int S = 1 << k;
      assign stg[k+1] = rot[k] ? {stg[k][S-1:0], stg[k][DATA_W-1:S]} : stg[k];
   end

   assign dout = stg[LOG_W];
endmodule

// File: rtl/opsh_core.sv
// Applies a canonical request: every shift is a rotation plus a fill mask.
module opsh_core
   import opsh_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 6
) (
   input  logic [DATA_W-1:0] data,
   input  shift_kind_e       kind,
   input  logic [AMT_W-1:0]  amt,
   input  logic              rrx,
   input  logic              hold,
   input  logic              c_in,
   output logic [DATA_W-1:0] res,
   output logic              c_out
);
   localparam int LOG_W = $clog2(DATA_W);
   localparam logic [DATA_W-1:0] ONES = '1;

   logic [LOG_W-1:0]  lo;
   logic [LOG_W-1:0]  neg_lo;
   logic [LOG_W-1:0]  rot_amt;
   logic [DATA_W-1:0] rotated;
   logic [DATA_W-1:0] mask_r;
   logic [DATA_W-1:0] mask_l;
   logic              full;
   logic              over;
   logic              sgn;

   assign lo      = amt[LOG_W-1:0];
   assign neg_lo  = ~lo + LOG_W'(1);
   assign rot_amt = (kind == SK_LSL) ? neg_lo : lo;
   assign mask_r  = ONES >> lo;
   assign mask_l  = ONES << lo;
   assign full    = (amt == AMT_W'(DATA_W));
   assign over    = (amt >  AMT_W'(DATA_W));
   assign sgn     = data[DATA_W-1];

   opsh_rotator #(.DATA_W(DATA_W), .LOG_W(LOG_W)) i_rot (
      .din  (data),
      .rot  (rot_amt),
      .dout (rotated)
   );

   always_comb begin
      res   = data;
      c_out = c_in;
      if (hold) begin
         res   = data;
         c_out = c_in;
      end else if (rrx) begin
         res   = {c_in, data[DATA_W-1:1]};
         c_out = data[0];
      end else begin
         case (kind)
            SK_LSL: begin
               if (over) begin
                  res = '0; c_out = 1'b0;
               end else if (full) begin
                  res = '0; c_out = data[0];
               end else begin
                  res = rotated & mask_l; c_out = data[neg_lo];
               end
            end
            SK_LSR: begin
               if (over) begin
                  res = '0; c_out = 1'b0;
               end else if (full) begin
                  res = '0; c_out = data[DATA_W-1];
               end else begin
                  res = rotated & mask_r; c_out = data[lo - LOG_W'(1)];
               end
            end
            SK_ASR: begin
               if (full || over) begin
                  res = {DATA_W{sgn}}; c_out = sgn;
               end else begin
                  res   = (rotated & mask_r) | (sgn ? ~mask_r : '0);
                  c_out = data[lo - LOG_W'(1)];
               end
            end
            default: begin
               res   = rotated;
               c_out = rotated[DATA_W-1];
            end
         endcase
      end
   end
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
   import opsh_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_AMT_W = 5,
   parameter int REG_AMT_W = 8,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4
) (
   input  logic [1:0]           src_sel,
   input  logic [1:0]           shift_kind,
   input  logic [DATA_W-1:0]    base_val,
   input  logic [REG_AMT_W-1:0] amt_byte,
   input  logic [IMM_AMT_W-1:0] imm_amt,
   input  logic [IMM_W-1:0]     imm_byte,
   input  logic [ROT_W-1:0]     imm_rot,
   input  logic                 c_in,
   output logic [DATA_W-1:0]    opnd_out,
   output logic                 c_out
);
   localparam int LOG_W = $clog2(DATA_W);
   localparam int AMT_W = $clog2(DATA_W + 2);

   if ((1 << LOG_W) != DATA_W) begin : g_chk_pow2
      $error("DATA_W must be a power of two");
   end
   if (IMM_AMT_W != LOG_W) begin : g_chk_imm_amt
      $error("IMM_AMT_W must equal log2(DATA_W)");
   end
   if (ROT_W + 1 != LOG_W) begin : g_chk_rot
      $error("twice the rotate field must span log2(DATA_W) bits");
   end
   if (IMM_W > DATA_W) begin : g_chk_imm
      $error("IMM_W wider than DATA_W");
   end
   if ((1 << REG_AMT_W) <= DATA_W + 1) begin : g_chk_reg_amt
      $error("REG_AMT_W cannot express an over-range amount");
   end

   opnd_src_e         src;
   shift_kind_e       kind;
   logic [DATA_W-1:0] p_data;
   shift_kind_e       p_kind;
   logic [AMT_W-1:0]  p_amt;
   logic              p_rrx;
   logic              p_hold;

   assign src  = opnd_src_e'(src_sel);
   assign kind = shift_kind_e'(shift_kind);

   opsh_plan #(
      .DATA_W(DATA_W), .IMM_AMT_W(IMM_AMT_W), .REG_AMT_W(REG_AMT_W),
      .IMM_W(IMM_W), .ROT_W(ROT_W), .AMT_W(AMT_W)
   ) i_plan (
      .src      (src),
      .kind     (kind),
      .reg_val  (base_val),
      .amt_byte (amt_byte),
      .imm_amt  (imm_amt),
      .imm_val  (imm_byte),
      .imm_rot  (imm_rot),
      .data     (p_data),
      .eff_kind (p_kind),
      .eff_amt  (p_amt),
      .rrx      (p_rrx),
      .hold     (p_hold)
   );

   opsh_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_core (
      .data  (p_data),
      .kind  (p_kind),
      .amt   (p_amt),
      .rrx   (p_rrx),
      .hold  (p_hold),
      .c_in  (c_in),
      .res   (opnd_out),
      .c_out (c_out)
   );

   always_comb begin
      if (src == OS_REG_AMT && amt_byte == '0)
         AST_REG_ZERO_HOLD: assert (opnd_out == base_val && c_out == c_in)
            else $error("zero register amount altered operand");   // R5
      if (src == OS_REG_AMT && (kind == SK_LSL || kind == SK_LSR) &&
          amt_byte > REG_AMT_W'(DATA_W))
         AST_LOGIC_OVERFLOW: assert (opnd_out == '0 && !c_out)
            else $error("logical over-range not cleared");   // R6
      if (src == OS_REG_AMT && kind == SK_ASR && amt_byte >= REG_AMT_W'(DATA_W))
         AST_ASR_SATURATE: assert (opnd_out == {DATA_W{base_val[DATA_W-1]}} &&
                                   c_out == base_val[DATA_W-1])
            else $error("arithmetic over-range not sign filled");   // R7
      if (src == OS_IMM_AMT && kind == SK_ROR && imm_amt == '0)
         AST_RRX_FORM: assert (opnd_out == {c_in, base_val[DATA_W-1:1]} &&
                               c_out == base_val[0])
            else $error("rotate through carry wrong");   // R3
      if (src == OS_ROT_IMM && imm_rot == '0)
         AST_ROT_ZERO_CARRY: assert (opnd_out == DATA_W'(imm_byte) && c_out == c_in)
            else $error("unrotated constant wrong");   // R9
      if (src == OS_RAW)
         AST_RAW_PASS: assert (opnd_out == base_val && c_out == c_in)
            else $error("raw source altered operand");   // R10
   end
endmodule

// File: tb/test_opnd_shifter.sv
module test_opnd_shifter;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [1:0]  src_sel = '0;
   logic [1:0]  shift_kind = '0;
   logic [31:0] base_val = '0;
   logic [7:0]  amt_byte = '0;
   logic [4:0]  imm_amt = '0;
   logic [7:0]  imm_byte = '0;
   logic [3:0]  imm_rot = '0;
   logic        c_in = 1'b0;
   logic [31:0] opnd_out;
   logic        c_out;

   int n_chk = 0;
   int n_fail = 0;

   opnd_shifter i_opnd_shifter (
      .src_sel(src_sel), .shift_kind(shift_kind), .base_val(base_val),
      .amt_byte(amt_byte), .imm_amt(imm_amt), .imm_byte(imm_byte),
      .imm_rot(imm_rot), .c_in(c_in), .opnd_out(opnd_out), .c_out(c_out)
   );

   // Reference: bitwise steps, one per shifted position; returns {carry, result}.
   function automatic logic [32:0] steps(input logic [1:0] k, input logic [31:0] v,
                                         input int n, input logic ci);
      logic [31:0] x = v;
      logic c = ci;
      for (int i = 0; i < n; i++) begin
         case (k)
            2'd0: begin c = x[31]; x = {x[30:0], 1'b0}; end
            2'd1: begin c = x[0];  x = {1'b0, x[31:1]}; end
            2'd2: begin c = x[0];  x = {x[31], x[31:1]}; end
            default: begin c = x[0]; x = {x[0], x[31:1]}; end
         endcase
      end
      return {c, x};
   endfunction

   function automatic logic [32:0] model(input logic [1:0] s, input logic [1:0] k,
                                         input logic [31:0] v, input logic [7:0] ab,
                                         input logic [4:0] ia, input logic [7:0] ib,
                                         input logic [3:0] ir, input logic ci);
      int n;
      case (s)
         2'd0: begin
            if (ia != 0) return steps(k, v, int'(ia), ci);
            if (k == 2'd0) return {ci, v};
            if (k == 2'd3) return {v[0], ci, v[31:1]};
            return steps(k, v, 32, ci);
         end
         2'd1: begin
            n = int'(ab);
            return steps(k, v, n, ci);
         end
         2'd2: begin
            n = 2 * int'(ir);
            return steps(2'd3, {24'd0, ib}, n, ci);
         end
         default: return {ci, v};
      endcase
   endfunction

   task automatic check_now(input string tag);
      logic [32:0] exp;
      exp = model(src_sel, shift_kind, base_val, amt_byte, imm_amt, imm_byte, imm_rot, c_in);
      n_chk++;
      if ({c_out, opnd_out} !== exp) begin
         n_fail++;
         $display("FAIL %s src=%0d kind=%0d val=%h: got c=%b op=%h, expected c=%b op=%h",
                  tag, src_sel, shift_kind, base_val, c_out, opnd_out, exp[32], exp[31:0]);
      end
   endtask

   task automatic apply(input logic [1:0] s, input logic [1:0] k, input logic [31:0] v,
                        input logic [7:0] ab, input logic [4:0] ia, input logic [7:0] ib,
                        input logic [3:0] ir, input logic ci, input string tag);
      @(negedge clk);
      src_sel = s; shift_kind = k; base_val = v; amt_byte = ab;
      imm_amt = ia; imm_byte = ib; imm_rot = ir; c_in = ci;
      #2;
      check_now(tag);
   endtask

   task automatic t_reset_state();
      @(negedge clk); #2;
      check_now("R4 reset");
   endtask

   task automatic t_imm_amount();
      logic [31:0] pats [3] = '{32'h8000_0001, 32'h7F3C_A5E1, 32'hC000_0002};
      int amts [4] = '{0, 1, 17, 31};
      string tag;
      for (int p = 0; p < 3; p++)
         for (int k = 0; k < 4; k++)
            for (int a = 0; a < 4; a++)
               for (int c = 0; c < 2; c++) begin
                  if (amts[a] != 0) tag = "R1";
                  else if (k == 0) tag = "R4";
                  else if (k == 3) tag = "R3";
                  else tag = "R2";
                  apply(2'd0, 2'(k), pats[p], 8'h0, 5'(amts[a]), 8'h0, 4'h0, 1'(c), tag);
               end
   endtask

   task automatic t_reg_amount();
      logic [31:0] pats [3] = '{32'h8000_0001, 32'h7F3C_A5E1, 32'hF0F0_1234};
      int amts [9] = '{0, 1, 5, 31, 32, 33, 64, 96, 255};
      string tag;
      for (int p = 0; p < 3; p++)
         for (int k = 0; k < 4; k++)
            for (int a = 0; a < 9; a++)
               for (int c = 0; c < 2; c++) begin
                  if (amts[a] == 0) tag = "R5";
                  else if (k < 2) tag = (amts[a] >= 32) ? "R6" : "R1";
                  else if (k == 2) tag = (amts[a] >= 32) ? "R7" : "R1";
                  else tag = "R8";
                  apply(2'd1, 2'(k), pats[p], 8'(amts[a]), 5'd0, 8'h0, 4'h0, 1'(c), tag);
               end
   endtask

   task automatic t_rot_imm();
      logic [7:0] cons [3] = '{8'hA5, 8'h01, 8'h80};
      for (int b = 0; b < 3; b++)
         for (int r = 0; r < 16; r++)
            for (int c = 0; c < 2; c++)
               apply(2'd2, 2'(r), 32'hDEAD_BEEF, 8'h21, 5'd7, cons[b], 4'(r), 1'(c), "R9");
   endtask

   task automatic t_raw();
      for (int k = 0; k < 4; k++)
         apply(2'd3, 2'(k), 32'h1357_9BDF, 8'd3, 5'd9, 8'hFF, 4'd5, 1'(k & 1), "R10");
   endtask

   task automatic t_sweep();
      logic [31:0] lf = 32'h1234_5678;
      for (int i = 0; i < 300; i++) begin
         lf ^= lf << 13; lf ^= lf >> 17; lf ^= lf << 5;
         apply(2'(lf[1:0] % 3), lf[3:2], {lf[15:0], lf[31:16]}, lf[11:4], lf[20:16],
               lf[29:22], lf[27:24], lf[30], "R1 sweep");
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_imm_amount();
      t_reg_amount();
      t_rot_imm();
      t_raw();
      t_sweep();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule